// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block is the register side of an SDRAM controller. Software sees only two words on a simple device-control bus. The first is an offset port and the second is a data port. A write to the offset port chooses an internal register, and any later access to the data port reads or writes that register. Behind the data port sit the following registers:

- two error status words that are cleared by writing 1s, plus an error address word;
- a global configuration word and a read-only status word;
- refresh, power-management, timing and ECC configuration words;
- an ECC error status word;
- one control word per memory bank.

Each register applies its own write mask, and the power-management word also forces some bits to 1. When the enable bit in the configuration word changes, the status word changes as a side effect. A hardware error reporter sets bits in the error status words and loads the error address. The block decodes each bank's base and size from its control word. It compares a probe address against every bank and reports which bank hits. It also drives an interrupt while the ECC error status is nonzero. The timing word goes out to the command sequencer, which lies outside this block.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A write to bus address 0x010 stores the full 32-bit offset, and a read of 0x010 returns it. A read of 0x011 returns the register at the current offset. Read data and `bus_rvalid` appear exactly one cycle after the `bus_rd` strobe. A read of any other bus address returns 0.
- R2: After reset the block holds these values. Configuration is 0x00800000, refresh is 0x05F00000, power-management is 0x07C00000 and the timing word is 0x00854009. The offset, the error status and address registers, the status word, the two ECC registers and all bank control words are 0. The interrupt and all bank hits are low.
- R3: The error status words are at offsets 0x00 and 0x08. A data-port write clears each bit that is written as 1 and keeps every other bit. A hardware report (`err_valid`, with `err_sel` 0 or 1 choosing the word) ORs `err_bits` into the chosen word. If a set and a clear hit the same bit in one cycle, the set wins.
- R4: A hardware report loads `err_addr` into the error address register at offset 0x10. A data-port write to 0x10 stores the full word.
- R5: The configuration word is at offset 0x20 and keeps only bits 31:21 of a write. If bit 31 changes from 0 to 1, status bit 31 is cleared. If bit 31 changes from 1 to 0, status bit 31 is set.
- R6: If configuration bit 30 rises, status bit 30 is set. If configuration bit 30 falls, status bit 30 is cleared. The status word is at offset 0x24 and ignores data-port writes.
- R7: Each of these offsets keeps only the bits of its mask:
  - refresh (offset 0x30) keeps 0x3FF80000;
  - timing (offset 0x80) keeps 0x018FC01F, and its value is seen on `timing_word`;
  - ECC configuration (offset 0x94) keeps 0x00F00000.
  The power-management word (offset 0x34) keeps bits 31:27 of a write and always reads bits 26:22 as 1.
- R8: A read of the timing offset, or of any offset that no register uses, returns 0xFFFFFFFF. A write to an unused offset changes no register.
- R9: Bank n has its control word at offset 0x40 + 4n and stores a write masked with 0xFFDEE001. Bit 0 marks the bank valid, bits 31:23 give the base address bits 31:23, and bits 19:17 give a size code that means 4 MiB << code.
- R10: Bank n hits the probe address only when all of the following hold:
  - configuration bit 31 is set;
  - the bank's valid bit is set;
  - the size code is not 7;
  - base <= address < base + size.
  A size code of 7 never hits.
- R11: `bank_hit` is one-hot with bit n meaning bank n. When several banks cover the address, only the lowest-numbered one is reported. `bank_hit_any` is high when any bank hits.
- R12: The ECC error status word is at offset 0x98 and stores a write masked with 0xFFF0F000. `ecc_irq` rises in the cycle after a write makes the register nonzero, and falls in the cycle after a write makes it zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Device-control bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| err_valid | input | 1 | Hardware error report strobe |
| err_sel | input | 1 | Error status word chosen by the report |
| err_bits | input | 32 | Bits to set in the chosen error status word |
| err_addr | input | 32 | Faulting address captured by a report |
| probe_addr | input | 32 | Address checked against the banks |
| bank_hit | output | NUM_BANKS | One-hot winning bank |
| bank_hit_any | output | 1 | Some bank covers `probe_addr` |
| timing_word | output | 32 | Current timing word |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The bench checks the exact bytes at each bank's range edge: the first address, the last address and the first address past the end. A design with an off-by-one in the range compare would claim the neighbouring bank's first address or drop its own last one. The bench sets two overlapping banks so that priority shows. It uses a size code of 7 placed where a naive shift would still cover the probe. It also clears the valid bit and the global enable, each of which must remove hits that were there a moment before. For the clear-by-writing-1 words, the bench sets and clears the same bit in one cycle; a design with the priority reversed loses that bit. It also toggles the enable both ways and checks that status bit 31 follows, and that a status write is dropped. A design that copied configuration into status, or let status be written, would read back the wrong word.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

  localparam int unsigned WORD_W = 32;

  // register offsets seen through the data port
  localparam logic [31:0] OFF_ERRSTAT0 = 32'h00;
  localparam logic [31:0] OFF_ERRSTAT1 = 32'h08;
  localparam logic [31:0] OFF_ERRADDR  = 32'h10;
  localparam logic [31:0] OFF_CONFIG   = 32'h20;
  localparam logic [31:0] OFF_STATUS   = 32'h24;
  localparam logic [31:0] OFF_REFRESH  = 32'h30;
  localparam logic [31:0] OFF_PWRMGT   = 32'h34;
  localparam logic [31:0] OFF_BANK0    = 32'h40;
  localparam logic [31:0] OFF_TIMING   = 32'h80;
  localparam logic [31:0] OFF_ECCCFG   = 32'h94;
  localparam logic [31:0] OFF_ECCSTAT  = 32'h98;

  // write masks and constants
  localparam logic [31:0] MASK_CONFIG  = 32'hFFE0_0000;
  localparam logic [31:0] MASK_REFRESH = 32'h3FF8_0000;
  localparam logic [31:0] MASK_PWRMGT  = 32'hF800_0000;
  localparam logic [31:0] FORCE_PWRMGT = 32'h07C0_0000;
  localparam logic [31:0] MASK_TIMING  = 32'h018F_C01F;
  localparam logic [31:0] MASK_ECCCFG  = 32'h00F0_0000;
  localparam logic [31:0] MASK_ECCSTAT = 32'hFFF0_F000;
  localparam logic [31:0] MASK_BANK    = 32'hFFDE_E001;

  localparam logic [31:0] RST_CONFIG   = 32'h0080_0000;
  localparam logic [31:0] RST_REFRESH  = 32'h05F0_0000;
  localparam logic [31:0] RST_TIMING   = 32'h0085_4009;

  localparam logic [32:0] MIN_BANK_BYTES = 33'd4194304;
  localparam logic [2:0]  BAD_SIZE_CODE  = 3'd7;

  // offset of the control word of bank idx
  function automatic logic [31:0] bank_offset(input int unsigned idx);
    return OFF_BANK0 + 32'(idx * 4);
  endfunction

  // bytes covered by a size code; the reserved code covers nothing
  function automatic logic [32:0] bank_span(input logic [2:0] code);
    if (code == BAD_SIZE_CODE) return 33'd0;
    return MIN_BANK_BYTES << code;
  endfunction

  function automatic logic [31:0] bank_base(input logic [31:0] ctl);
    return {ctl[31:23], 23'd0};
  endfunction

  // true when ctl describes a valid bank that contains addr
  function automatic logic bank_covers(input logic [31:0] ctl,
                                       input logic [31:0] addr);
    logic [31:0] base;
    logic [31:0] diff;
    logic [32:0] span;
    base = bank_base(ctl);
    span = bank_span(ctl[19:17]);
    diff = addr - base;
    return ctl[0] && (ctl[19:17] != BAD_SIZE_CODE) &&
           (addr >= base) && ({1'b0, diff} < span);
  endfunction

endpackage

// File: rtl/sdrc_port.sv
module sdrc_port #(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OFFSET_PORT = 10'h010,
  parameter logic [ADDR_W-1:0] DATA_PORT   = 10'h011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  input  logic [31:0]       reg_word,
  output logic [31:0]       cur_off,
  output logic              data_we,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);

  logic [31:0] off_q;
  logic        hit_off;
  logic        hit_data;
  logic [31:0] rd_mux;

  assign hit_off  = (bus_addr == OFFSET_PORT);
  assign hit_data = (bus_addr == DATA_PORT);
  assign data_we  = bus_wr && hit_data;
  assign cur_off  = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= '0;
    else if (bus_wr && hit_off) off_q <= bus_wdata;
  end

  always_comb begin
    if (hit_off)       rd_mux = off_q;
    else if (hit_data) rd_mux = reg_word;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R1: a strobe is answered exactly one cycle later
  a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R1: the offset port captures the written word
  a_r1_offset_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_off) |=> (cur_off == $past(bus_wdata)));

endmodule

// File: rtl/sdrc_regs.sv
module sdrc_regs
  import sdrc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            cur_off,
  input  logic                   data_we,
  input  logic [31:0]            wdata,
  input  logic                   err_valid,
  input  logic                   err_sel,
  input  logic [31:0]            err_bits,
  input  logic [31:0]            err_addr,
  output logic [31:0]            reg_word,
  output logic                   map_en,
  output logic [NUM_BANKS*32-1:0] bank_ctl_flat,
  output logic [31:0]            timing_word,
  output logic                   ecc_irq
);

  logic [31:0] errstat0_q, errstat1_q, erraddr_q;
  logic [31:0] config_q, refresh_q, pwrmgt_q, timing_q;
  logic [31:0] ecccfg_q, eccstat_q;
  logic [1:0]  stat_q;          // status bits 31:30
  logic        irq_q;
  logic [31:0] bank_q [NUM_BANKS];

  // named write events, one per register
  logic wr_err0, wr_err1, wr_eaddr, wr_cfg, wr_ref, wr_pm, wr_tim;
  logic wr_ecfg, wr_estat;
  logic set_err0, set_err1;
  logic [31:0] cfg_new, estat_new;
  logic en_rise, en_fall, b30_rise, b30_fall;
  logic [31:0] errstat0_n, errstat1_n;

  assign wr_err0  = data_we && (cur_off == OFF_ERRSTAT0);
  assign wr_err1  = data_we && (cur_off == OFF_ERRSTAT1);
  assign wr_eaddr = data_we && (cur_off == OFF_ERRADDR);
  assign wr_cfg   = data_we && (cur_off == OFF_CONFIG);
  assign wr_ref   = data_we && (cur_off == OFF_REFRESH);
  assign wr_pm    = data_we && (cur_off == OFF_PWRMGT);
  assign wr_tim   = data_we && (cur_off == OFF_TIMING);
  assign wr_ecfg  = data_we && (cur_off == OFF_ECCCFG);
  assign wr_estat = data_we && (cur_off == OFF_ECCSTAT);
  assign set_err0 = err_valid && !err_sel;
  assign set_err1 = err_valid &&  err_sel;

  assign cfg_new   = wdata & MASK_CONFIG;
  assign estat_new = wdata & MASK_ECCSTAT;
  assign en_rise   = wr_cfg && !config_q[31] &&  cfg_new[31];
  assign en_fall   = wr_cfg &&  config_q[31] && !cfg_new[31];
  assign b30_rise  = wr_cfg && !config_q[30] &&  cfg_new[30];
  assign b30_fall  = wr_cfg &&  config_q[30] && !cfg_new[30];

  // clear-by-one first, then the hardware set, so a set wins
  always_comb begin
    errstat0_n = errstat0_q;
    errstat1_n = errstat1_q;
    if (wr_err0)  errstat0_n = errstat0_n & ~wdata;
    if (wr_err1)  errstat1_n = errstat1_n & ~wdata;
    if (set_err0) errstat0_n = errstat0_n | err_bits;
    if (set_err1) errstat1_n = errstat1_n | err_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errstat0_q <= '0;
      errstat1_q <= '0;
      erraddr_q  <= '0;
    end else begin
      errstat0_q <= errstat0_n;
      errstat1_q <= errstat1_n;
      if (err_valid)     erraddr_q <= err_addr;
      else if (wr_eaddr) erraddr_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      config_q <= RST_CONFIG;
      stat_q   <= 2'b00;
    end else if (wr_cfg) begin
      config_q <= cfg_new;
      if (en_rise)       stat_q[1] <= 1'b0;
      else if (en_fall)  stat_q[1] <= 1'b1;
      if (b30_rise)      stat_q[0] <= 1'b1;
      else if (b30_fall) stat_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refresh_q <= RST_REFRESH;
      pwrmgt_q  <= FORCE_PWRMGT;
      timing_q  <= RST_TIMING;
      ecccfg_q  <= '0;
    end else begin
      if (wr_ref)  refresh_q <= wdata & MASK_REFRESH;
      if (wr_pm)   pwrmgt_q  <= (wdata & MASK_PWRMGT) | FORCE_PWRMGT;
      if (wr_tim)  timing_q  <= wdata & MASK_TIMING;
      if (wr_ecfg) ecccfg_q  <= wdata & MASK_ECCCFG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eccstat_q <= '0;
      irq_q     <= 1'b0;
    end else if (wr_estat) begin
      eccstat_q <= estat_new;
      irq_q     <= |estat_new;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [31:0] MY_OFF = bank_offset(g);
    logic wr_bank;
    assign wr_bank = data_we && (cur_off == MY_OFF);
    always_ff @(posedge clk) begin
      if (!rst_n)       bank_q[g] <= '0;
      else if (wr_bank) bank_q[g] <= wdata & MASK_BANK;
    end
    assign bank_ctl_flat[g*32 +: 32] = bank_q[g];

    // R9: a bank write stores only the masked bits
    a_r9_bank_mask: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bank |=> ((bank_q[g] & ~MASK_BANK) == '0));
  end

  always_comb begin
    unique case (cur_off)
      OFF_ERRSTAT0: reg_word = errstat0_q;
      OFF_ERRSTAT1: reg_word = errstat1_q;
      OFF_ERRADDR:  reg_word = erraddr_q;
      OFF_CONFIG:   reg_word = config_q;
      OFF_STATUS:   reg_word = {stat_q, 30'd0};
      OFF_REFRESH:  reg_word = refresh_q;
      OFF_PWRMGT:   reg_word = pwrmgt_q;
      OFF_ECCCFG:   reg_word = ecccfg_q;
      OFF_ECCSTAT:  reg_word = eccstat_q;
      default:      reg_word = '1;
    endcase
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (cur_off == bank_offset(i)) reg_word = bank_q[i];
    end
  end

  assign map_en      = config_q[31];
  assign timing_word = timing_q;
  assign ecc_irq     = irq_q;

  // R3: written ones clear unless the reporter sets them in the same cycle
  a_r3_clear_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err0 && !set_err0) |=> ((errstat0_q & $past(wdata)) == '0));
  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_err1 |=> ((errstat1_q & $past(err_bits)) == $past(err_bits)));
  // R5: enabling clears status bit 31
  a_r5_enable_edge: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!stat_q[1] && map_en));
  a_r5_disable_edge: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> (stat_q[1] && !map_en));
  // R6: status changes only through a configuration write
  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(stat_q));
  // R7: power-management forced bits never drop
  a_r7_pm_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrmgt_q & FORCE_PWRMGT) == FORCE_PWRMGT);
  // R12: the interrupt follows the written ECC status
  a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_estat && (estat_new != '0)) |=> ecc_irq);
  a_r12_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_estat && (estat_new == '0)) |=> !ecc_irq);

endmodule

// File: rtl/sdrc_bank_match.sv
module sdrc_bank_match
  import sdrc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                    map_en,
  input  logic [NUM_BANKS*32-1:0] bank_ctl_flat,
  input  logic [31:0]             probe_addr,
  output logic [NUM_BANKS-1:0]    hit_raw,
  output logic [NUM_BANKS-1:0]    hit_vec
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    assign hit_raw[g] = map_en && bank_covers(bank_ctl_flat[g*32 +: 32], probe_addr);
  end

  // isolate the lowest set bit: lowest-numbered bank wins
  assign hit_vec = hit_raw & (~hit_raw + {{(NUM_BANKS-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdrc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] OFFSET_PORT = 10'h010,
  parameter logic [ADDR_W-1:0] DATA_PORT   = 10'h011
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic                 err_valid,
  input  logic                 err_sel,
  input  logic [31:0]          err_bits,
  input  logic [31:0]          err_addr,
  input  logic [31:0]          probe_addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 bank_hit_any,
  output logic [31:0]          timing_word,
  output logic                 ecc_irq
);

  logic [31:0]             cur_off;
  logic                    data_we;
  logic [31:0]             reg_word;
  logic                    map_en;
  logic [NUM_BANKS*32-1:0] bank_ctl_flat;
  logic [NUM_BANKS-1:0]    hit_raw;

  sdrc_port #(
    .ADDR_W(ADDR_W), .OFFSET_PORT(OFFSET_PORT), .DATA_PORT(DATA_PORT)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .reg_word(reg_word),
    .cur_off(cur_off), .data_we(data_we), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  sdrc_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cur_off(cur_off), .data_we(data_we),
    .wdata(bus_wdata), .err_valid(err_valid), .err_sel(err_sel),
    .err_bits(err_bits), .err_addr(err_addr), .reg_word(reg_word),
    .map_en(map_en), .bank_ctl_flat(bank_ctl_flat),
    .timing_word(timing_word), .ecc_irq(ecc_irq)
  );

  sdrc_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .map_en(map_en), .bank_ctl_flat(bank_ctl_flat), .probe_addr(probe_addr),
    .hit_raw(hit_raw), .hit_vec(bank_hit)
  );

  assign bank_hit_any = |hit_raw;

  // R11: at most one winner, and a winner exists whenever some bank matched
  a_r11_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  a_r11_winner_present: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_raw != '0) |-> (bank_hit != '0));
  // R10: no hit while mapping is disabled
  a_r10_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> (bank_hit == '0));

endmodule

// File: tb/tb_sdram_cfg_regfile.sv
module tb_sdram_cfg_regfile;

  localparam int NB = 4;
  localparam logic [9:0] P_OFF = 10'h010;
  localparam logic [9:0] P_DAT = 10'h011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        err_valid = 1'b0, err_sel = 1'b0;
  logic [31:0] err_bits = '0, err_addr = '0, probe_addr = '0;
  logic [NB-1:0] bank_hit;
  logic        bank_hit_any;
  logic [31:0] timing_word;
  logic        ecc_irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  sdram_cfg_regfile #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .err_valid(err_valid), .err_sel(err_sel),
    .err_bits(err_bits), .err_addr(err_addr), .probe_addr(probe_addr),
    .bank_hit(bank_hit), .bank_hit_any(bank_hit_any),
    .timing_word(timing_word), .ecc_irq(ecc_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R1 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [31:0] off, input logic [31:0] d);
    bus_write(P_OFF, off);
    bus_write(P_DAT, d);
  endtask

  task automatic reg_read(input logic [31:0] off, input logic [31:0] exp, input string tag);
    bus_write(P_OFF, off);
    bus_read(P_DAT, exp, tag);
  endtask

  task automatic report_err(input logic sel, input logic [31:0] bits, input logic [31:0] a);
    @(negedge clk);
    err_valid = 1'b1; err_sel = sel; err_bits = bits; err_addr = a;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic [NB-1:0] exp, input string tag);
    @(negedge clk);
    probe_addr = a;
    #1;
    check(tag, 32'(bank_hit), 32'(exp));
    check(tag, 32'(bank_hit_any), 32'(exp != '0));
  endtask

  initial begin : watchdog
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset state on the ports
    check("R2 irq", 32'(ecc_irq), 32'd0);
    check("R2 timing", timing_word, 32'h0085_4009);
    check("R2 rvalid", 32'(bus_rvalid), 32'd0);
    bus_read(P_OFF, 32'h0, "R2 offset");
    reg_read(32'h20, 32'h0080_0000, "R2 config");
    reg_read(32'h24, 32'h0, "R2 status");
    reg_read(32'h30, 32'h05F0_0000, "R2 refresh");
    reg_read(32'h34, 32'h07C0_0000, "R2 pwrmgt");
    reg_read(32'h00, 32'h0, "R2 errstat0");
    reg_read(32'h98, 32'h0, "R2 eccstat");
    reg_read(32'h4C, 32'h0, "R2 bank3");
    probe(32'h0, 4'b0000, "R2 no hit");

    // R1 offset port and stray bus address
    bus_write(P_OFF, 32'hCAFE_0123);
    bus_read(P_OFF, 32'hCAFE_0123, "R1 offset readback");
    bus_read(10'h0FF, 32'h0, "R1 other bus addr");

    // R5 / R6 config edges and status
    reg_write(32'h20, 32'hC01F_FFFF);
    reg_read(32'h20, 32'hC000_0000, "R5 config mask");
    reg_read(32'h24, 32'h4000_0000, "R6 bit30 rise");
    reg_write(32'h24, 32'hFFFF_FFFF);
    reg_read(32'h24, 32'h4000_0000, "R6 status ignores write");
    reg_write(32'h20, 32'h0);
    reg_read(32'h24, 32'h8000_0000, "R5 disable sets bit31");
    reg_write(32'h20, 32'h8000_0000);
    reg_read(32'h24, 32'h0, "R5 enable clears bit31");

    // R7 masks
    reg_write(32'h30, 32'hFFFF_FFFF);
    reg_read(32'h30, 32'h3FF8_0000, "R7 refresh");
    reg_write(32'h34, 32'h0);
    reg_read(32'h34, 32'h07C0_0000, "R7 pwrmgt forced");
    reg_write(32'h34, 32'hFFFF_FFFF);
    reg_read(32'h34, 32'hFFC0_0000, "R7 pwrmgt full");
    reg_write(32'h80, 32'hFFFF_FFFF);
    check("R7 timing out", timing_word, 32'h018F_C01F);
    reg_write(32'h94, 32'hFFFF_FFFF);
    reg_read(32'h94, 32'h00F0_0000, "R7 ecccfg");

    // R8 all-ones reads and ignored writes
    reg_read(32'h80, 32'hFFFF_FFFF, "R8 timing reads ones");
    reg_write(32'h04, 32'h0);
    reg_read(32'h04, 32'hFFFF_FFFF, "R8 unmapped");
    reg_read(32'h30, 32'h3FF8_0000, "R8 refresh untouched");

    // R3 / R4 error registers
    report_err(1'b0, 32'hA5A5_0000, 32'h1234_5678);
    reg_read(32'h00, 32'hA5A5_0000, "R3 set");
    reg_read(32'h10, 32'h1234_5678, "R4 capture");
    reg_write(32'h00, 32'h8080_0000);
    reg_read(32'h00, 32'h2525_0000, "R3 clear by one");
    bus_write(P_OFF, 32'h00);
    @(negedge clk);
    bus_addr = P_DAT; bus_wdata = 32'h0000_0001; bus_wr = 1'b1;
    err_valid = 1'b1; err_sel = 1'b0; err_bits = 32'h0000_0001; err_addr = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0; err_valid = 1'b0;
    reg_read(32'h00, 32'h2525_0001, "R3 set wins");
    report_err(1'b1, 32'h0000_FFFF, 32'h0);
    reg_read(32'h08, 32'h0000_FFFF, "R3 errstat1 set");
    reg_write(32'h08, 32'hFFFF_FFFF);
    reg_read(32'h08, 32'h0, "R3 errstat1 clear");
    reg_write(32'h10, 32'hDEAD_BEEF);
    reg_read(32'h10, 32'hDEAD_BEEF, "R4 bus write");

    // R12 ECC status and interrupt
    reg_write(32'h98, 32'hFFFF_FFFF);
    check("R12 irq rise", 32'(ecc_irq), 32'd1);
    reg_read(32'h98, 32'hFFF0_F000, "R12 mask");
    reg_write(32'h98, 32'h000F_0FFF);
    check("R12 irq fall", 32'(ecc_irq), 32'd0);
    reg_write(32'h98, 32'h0000_1000);
    check("R12 irq single bit", 32'(ecc_irq), 32'd1);
    reg_write(32'h98, 32'h0);

    // R9 bank mask, R10 / R11 decode (mapping enabled above)
    reg_write(32'h44, 32'hFFFF_FFFF);
    reg_read(32'h44, 32'hFFDE_E001, "R9 bank mask");
    reg_write(32'h40, 32'h0002_0001);  // 0..8MiB
    reg_write(32'h44, 32'h0080_0001);  // 8..12MiB
    reg_write(32'h48, 32'h100E_0001);  // reserved size code
    reg_write(32'h4C, 32'h000C_0001);  // 0..256MiB
    reg_read(32'h4C, 32'h000C_0001, "R9 bank3 readback");
    probe(32'h0000_0000, 4'b0001, "R11 overlap low wins");
    probe(32'h007F_FFFF, 4'b0001, "R10 bank0 last byte");
    probe(32'h0080_0000, 4'b0010, "R11 bank1 over bank3");
    probe(32'h00BF_FFFF, 4'b0010, "R10 bank1 last byte");
    probe(32'h00C0_0000, 4'b1000, "R10 bank1 end");
    probe(32'h0FFF_FFFF, 4'b1000, "R10 bank3 last byte");
    probe(32'h1000_0000, 4'b0000, "R10 code7 no hit");
    reg_write(32'h20, 32'h0);
    probe(32'h0000_0000, 4'b0000, "R10 disabled");
    reg_write(32'h20, 32'h8000_0000);
    reg_write(32'h40, 32'h0002_0000);
    probe(32'h0000_0000, 4'b1000, "R10 valid bit off");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("R1 missing read data", 32'(exp_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule